// File: doc/BRIEF.md
# Key-Protected Control Register File

This block is a bank of 32-bit system control words behind a simple single-cycle bus. Software addresses it in bytes, four per word. The word at byte 0x00 is a protection key. Writing one specific magic value there unlocks the low part of the map. Writing anything else locks it again. While the block is locked, stores to the protected span are thrown away, and a one-cycle error pulse reports each dropped store.

Two addresses behave in unusual ways. The hardware strap word at byte 0x70 only ever gains bits, because a store there ORs its data into the stored value. A store to the revision word at byte 0x7C does not touch the revision. Instead it clears the strap bits where the data holds ones. A fixed set of read-only words ignores stores. A read of byte 0x78 returns the random word present on an input port, so every read can return a fresh value. At reset most words take constants. The key, revision and both strap words load from input ports.

Top module: `cr_keyfile`

## Requirements
- R1: A store to byte 0x00 sets the key word to 1 when the data equals UNLOCK_KEY and to 0 for any other data. The store is never blocked. `unlocked` shows bit 0 of the key word.
- R2: While the key word is 0, stores to bytes 0x04 through 0x100 (word indices 1 to 64) leave every register unchanged.
- R3: An accepted store to byte 0x70 makes the strap word equal to its old value ORed with the data.
- R4: An accepted store to byte 0x7C ANDs the strap word with the inverted data and leaves the revision word unchanged.
- R5: Stores to the read-only bytes 0x14, 0x50–0x6C, 0x78, 0xE0, 0xE4, 0x150 and 0x154 leave every register unchanged.
- R6: Bytes at or above NUM_REGS*4 (0x1A8) read as 0, and a store to them changes nothing and raises no error.
- R7: A read of byte 0x78 returns the value on `rng_in` in the request cycle.
- R8: During reset, byte 0x00 holds `key_in`, 0x70 holds `strap_a_in`, 0xD0 holds `strap_b_in` and 0x7C holds `rev_in`. The other words take fixed defaults, for example 0x04 = 0xFFCFFEDC and 0x150 = 0x1234ABCD, and words without a default are 0.
- R9: A request with a nonzero byte offset in bits [1:0] is refused: a store changes nothing and raises no error, and a read returns 0.
- R10: `wr_err` is high for exactly the cycle after a store that R2 or R5 dropped. It stays low after every other request.
- R11: `bus_rvalid` is high for the one cycle after each read request and low after stores. `bus_rdata` is valid while `bus_rvalid` is high.
- R12: An accepted store to any other writable word replaces the whole word. Words from 0x104 upward accept stores even while the block is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = store, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Store data |
| bus_rdata | output | DATA_W | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| wr_err | output | 1 | Pulse after a locked or read-only store is dropped |
| unlocked | output | 1 | Key word bit 0 |
| key_in | input | 1 | Reset value of the key word |
| strap_a_in | input | DATA_W | Reset value of the strap word at 0x70 |
| strap_b_in | input | DATA_W | Reset value of the strap word at 0xD0 |
| rev_in | input | DATA_W | Reset value of the revision word |
| rng_in | input | DATA_W | Random word returned at 0x78 |

## Verification
A wrong lock state shows at the ports within one cycle, as a missing or spurious `wr_err` pulse. A wrong stored word, whether from a bad strap merge, a corrupted revision or a write that leaked past the lock, stays hidden until software reads that word back. The bench therefore follows every store with a readback and also reads random addresses. A wrong reset default shows up on the sweep of all words that follows reset.

// File: rtl/kcr_pkg.sv
package kcr_pkg;

  localparam int unsigned IDX_KEY     = 0;
  localparam int unsigned IDX_STRAP_A = 28;
  localparam int unsigned IDX_RNG     = 30;
  localparam int unsigned IDX_REV     = 31;
  localparam int unsigned IDX_STRAP_B = 52;
  localparam int unsigned LOCK_LIMIT  = 65;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_KEY,
    ACT_PLAIN,
    ACT_STRAP_SET,
    ACT_STRAP_CLR,
    ACT_DROP_LOCK,
    ACT_DROP_RO
  } wr_act_e;

  function automatic logic [31:0] reset_word(int unsigned idx);
    case (idx)
      1:   return 32'hFFCF_FEDC;
      2:   return 32'hF3F4_0000;
      3:   return 32'h19FC_3E8B;
      7:   return 32'h0002_6108;
      8:   return 32'h0003_0291;
      9:   return 32'h9300_0400;
      11:  return 32'h0000_0010;
      12:  return 32'h2000_1A03;
      13:  return 32'h2000_1A03;
      14:  return 32'h0400_0030;
      15:  return 32'h0000_0001;
      16:  return 32'h0000_00C0;
      19:  return 32'h0000_0023;
      29:  return 32'h0000_000E;
      33:  return 32'h0000_F000;
      34:  return 32'h0300_0000;
      36:  return 32'h0000_A000;
      39:  return 32'h023F_FFF3;
      41:  return 32'hFFFF_0000;
      42:  return 32'h000F_FFFF;
      56:  return 32'h0000_00FF;
      57:  return 32'h0000_00FF;
      65:  return 32'h8000_0000;
      68:  return 32'h1E60_0000;
      69:  return 32'hC000_0000;
      84:  return 32'h1234_ABCD;
      85:  return 32'h8888_4444;
      88:  return 32'h0000_1903;
      96:  return 32'h0000_007B;
      105: return 32'h0000_2402;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic is_read_only(int unsigned idx);
    return (idx == 5) || (idx >= 20 && idx <= 27) || (idx == IDX_RNG) ||
           (idx == 56) || (idx == 57) || (idx == 84) || (idx == 85);
  endfunction

  function automatic logic in_lock_span(int unsigned idx);
    return (idx > IDX_KEY) && (idx < LOCK_LIMIT);
  endfunction

endpackage

// File: rtl/cr_decode.sv
module cr_decode
  import kcr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_REGS   = 106,
  parameter logic [31:0] UNLOCK_KEY = 32'h5EC7_19A2,
  localparam int unsigned IDX_W     = ADDR_W - 2
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              unlocked,
  output wr_act_e           act,
  output logic [IDX_W-1:0]  widx,
  output logic              acc_ok,
  output logic              key_match
);

  logic aligned;
  logic in_range;

  assign widx      = addr[ADDR_W-1:2];
  assign aligned   = (addr[1:0] == 2'b00);
  assign in_range  = (int'(widx) < int'(NUM_REGS));
  assign acc_ok    = aligned && in_range;
  assign key_match = (wdata == DATA_W'(UNLOCK_KEY));

  always_comb begin
    act = ACT_NONE;
    if (sel && wr && acc_ok) begin
      if (int'(widx) == IDX_KEY)                          act = ACT_KEY;
      else if (!unlocked && in_lock_span(int'(widx)))     act = ACT_DROP_LOCK;
      else if (int'(widx) == IDX_STRAP_A)                 act = ACT_STRAP_SET;
      else if (int'(widx) == IDX_REV)                     act = ACT_STRAP_CLR;
      else if (is_read_only(int'(widx)))                  act = ACT_DROP_RO;
      else                                                act = ACT_PLAIN;
    end
  end

endmodule

// File: rtl/cr_bank.sv
module cr_bank
  import kcr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 106,
  localparam int unsigned IDX_W   = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_act_e           act,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              key_match,
  input  logic              key_in,
  input  logic [DATA_W-1:0] strap_a_in,
  input  logic [DATA_W-1:0] strap_b_in,
  input  logic [DATA_W-1:0] rev_in,
  output logic [DATA_W-1:0] regs_q [NUM_REGS]
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    logic [DATA_W-1:0] init_v;
    logic [DATA_W-1:0] next_v;

    if (i == IDX_KEY) begin : g_key
      assign init_v = DATA_W'(key_in);
      assign next_v = (act == ACT_KEY) ? DATA_W'(key_match) : regs_q[i];
    end else if (i == IDX_STRAP_A) begin : g_strap
      assign init_v = strap_a_in;
      always_comb begin
        case (act)
          ACT_STRAP_SET: next_v = regs_q[i] | wdata;
          ACT_STRAP_CLR: next_v = regs_q[i] & ~wdata;
          default:       next_v = regs_q[i];
        endcase
      end
    end else begin : g_plain
      if (i == IDX_REV) begin : g_rev
        assign init_v = rev_in;
      end else if (i == IDX_STRAP_B) begin : g_strap_b
        assign init_v = strap_b_in;
      end else begin : g_const
        assign init_v = DATA_W'(reset_word(i));
      end
      assign next_v = (act == ACT_PLAIN && widx == IDX_W'(i)) ? wdata : regs_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= init_v;
      else        regs_q[i] <= next_v;
    end
  end

endmodule

// File: rtl/cr_keyfile.sv
module cr_keyfile
  import kcr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_REGS   = 106,
  parameter logic [31:0] UNLOCK_KEY = 32'h5EC7_19A2,
  localparam int unsigned IDX_W     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              wr_err,
  output logic              unlocked,
  input  logic              key_in,
  input  logic [DATA_W-1:0] strap_a_in,
  input  logic [DATA_W-1:0] strap_b_in,
  input  logic [DATA_W-1:0] rev_in,
  input  logic [DATA_W-1:0] rng_in
);

  wr_act_e           act;
  logic [IDX_W-1:0]  widx;
  logic              acc_ok;
  logic              key_match;
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [IDX_W-1:0]  ridx;
  logic              rd_fire;
  logic              drop_evt;

  cr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .unlocked(unlocked), .act(act), .widx(widx), .acc_ok(acc_ok),
    .key_match(key_match)
  );

  cr_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .act(act), .widx(widx), .wdata(bus_wdata),
    .key_match(key_match), .key_in(key_in), .strap_a_in(strap_a_in),
    .strap_b_in(strap_b_in), .rev_in(rev_in), .regs_q(regs_q)
  );

  assign unlocked = regs_q[IDX_KEY][0];
  assign rd_fire  = bus_sel && !bus_wr;
  assign ridx     = acc_ok ? widx : '0;
  assign drop_evt = (act == ACT_DROP_LOCK) || (act == ACT_DROP_RO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      wr_err     <= 1'b0;
    end else begin
      bus_rvalid <= rd_fire;
      wr_err     <= drop_evt;
      if (rd_fire) begin
        if (!acc_ok)                      bus_rdata <= '0;
        else if (int'(widx) == IDX_RNG)   bus_rdata <= rng_in;
        else                              bus_rdata <= regs_q[ridx];
      end
    end
  end

  AST_KEY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_KEY) |=> (unlocked == ($past(bus_wdata) == DATA_W'(UNLOCK_KEY)))); // R1

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DROP_LOCK) |=> (regs_q[$past(ridx)] == $past(regs_q[ridx]))); // R2

  AST_STRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STRAP_SET) |=>
      (regs_q[IDX_STRAP_A] == ($past(regs_q[IDX_STRAP_A]) | $past(bus_wdata)))); // R3

  AST_STRAP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STRAP_CLR) |=>
      ((regs_q[IDX_STRAP_A] == ($past(regs_q[IDX_STRAP_A]) & ~$past(bus_wdata))) &&
       $stable(regs_q[IDX_REV]))); // R4

  AST_RO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DROP_RO) |=> (regs_q[$past(ridx)] == $past(regs_q[ridx]))); // R5

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr) |=> !bus_rvalid); // R11

endmodule

// File: tb/sim_cr_keyfile.sv
module sim_cr_keyfile;
  localparam int unsigned NREG = 106;
  localparam logic [31:0] KEY  = 32'h5EC7_19A2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, wr_err, unlocked;
  logic key_in = 1'b0;
  logic [31:0] strap_a_in = 32'h00F0_0A05;
  logic [31:0] strap_b_in = 32'h1357_9BDF;
  logic [31:0] rev_in     = 32'h0403_0303;
  logic [31:0] rng_in     = 32'h0;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [31:0] model [NREG];

  always #2.5 clk = ~clk;

  cr_keyfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .wr_err(wr_err), .unlocked(unlocked),
    .key_in(key_in), .strap_a_in(strap_a_in), .strap_b_in(strap_b_in),
    .rev_in(rev_in), .rng_in(rng_in)
  );

  function automatic logic [31:0] b_default(int i);
    logic [31:0] v = 32'h0;
    case (i)
      1: v = 32'hFFCFFEDC;  2: v = 32'hF3F40000;  3: v = 32'h19FC3E8B;
      7: v = 32'h00026108;  8: v = 32'h00030291;  9: v = 32'h93000400;
      11: v = 32'h10;       12: v = 32'h20001A03; 13: v = 32'h20001A03;
      14: v = 32'h04000030; 15: v = 32'h1;        16: v = 32'hC0;
      19: v = 32'h23;       29: v = 32'hE;        33: v = 32'hF000;
      34: v = 32'h03000000; 36: v = 32'hA000;     39: v = 32'h023FFFF3;
      41: v = 32'hFFFF0000; 42: v = 32'h000FFFFF; 56: v = 32'hFF;
      57: v = 32'hFF;       65: v = 32'h80000000; 68: v = 32'h1E600000;
      69: v = 32'hC0000000; 84: v = 32'h1234ABCD; 85: v = 32'h88884444;
      88: v = 32'h1903;     96: v = 32'h7B;       105: v = 32'h2402;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  function automatic bit b_ro(int i);
    return i == 5 || (i >= 20 && i <= 27) || i == 30 || i == 56 || i == 57 ||
           i == 84 || i == 85;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model of one store; returns the expected error pulse.
  function automatic bit model_store(logic [11:0] a, logic [31:0] d);
    int i = int'(a[11:2]);
    if (a[1:0] != 0 || i >= NREG) return 0;
    if (i == 0) begin model[0] = (d == KEY) ? 32'h1 : 32'h0; return 0; end
    if (model[0][0] == 1'b0 && i < 65) return 1;
    if (i == 28) begin model[28] = model[28] | d; return 0; end
    if (i == 31) begin model[28] = model[28] & ~d; return 0; end
    if (b_ro(i)) return 1;
    model[i] = d;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a, logic [31:0] rng);
    int i = int'(a[11:2]);
    if (a[1:0] != 0 || i >= NREG) return 32'h0;
    if (i == 30) return rng;
    return model[i];
  endfunction

  function automatic string tag_of(logic [11:0] a);
    int i = int'(a[11:2]);
    if (a[1:0] != 0) return "R9";
    if (i >= NREG) return "R6";
    if (i == 30) return "R7";
    if (i == 28 || i == 31) return "R3/R4";
    if (b_ro(i)) return "R5";
    if (i < 65) return "R2/R12";
    return "R12";
  endfunction

  task automatic do_write(logic [11:0] a, logic [31:0] d, string req);
    bit exp_err;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0;
    exp_err = model_store(a, d);
    chk(wr_err == exp_err, {req, " R10 err"}, 32'(wr_err), 32'(exp_err));
    chk(bus_rvalid == 1'b0, "R11 no rvalid on store", 32'(bus_rvalid), 0);
  endtask

  task automatic do_read(logic [11:0] a, string req);
    logic [31:0] e;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; rng_in = $urandom;
    e = model_read(a, rng_in);
    @(posedge clk); #1;
    bus_sel = 0;
    chk(bus_rvalid == 1'b1, "R11 rvalid", 32'(bus_rvalid), 1);
    chk(bus_rdata == e, req, bus_rdata, e);
    chk(wr_err == 1'b0, "R10 no err on read", 32'(wr_err), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) model[i] = b_default(i);
    model[0] = {31'b0, key_in};
    model[28] = strap_a_in; model[31] = rev_in; model[52] = strap_b_in;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R8: reset contents
    chk(unlocked == 1'b0, "R8 key from input", 32'(unlocked), 0);
    chk(bus_rvalid == 1'b0 && wr_err == 1'b0, "R8 outputs idle",
        {30'b0, bus_rvalid, wr_err}, 0);
    for (int i = 0; i < NREG; i++) if (i != 30) do_read(12'(i * 4), "R8 reset word");
    do_read(12'h1A8, "R6 out of range read");

    // R2: locked store dropped
    do_write(12'h004, 32'h1111_2222, "R2 locked store");
    do_read(12'h004, "R2 locked word held");
    do_write(12'h070, 32'hFFFF_FFFF, "R2 locked strap");
    do_read(12'h070, "R2 strap held");
    // R12: above the span
    do_write(12'h104, 32'hCAFE_0001, "R12 open store");
    do_read(12'h104, "R12 open readback");
    // R1: key
    do_write(12'h000, KEY ^ 32'h1, "R1 wrong key");
    do_read(12'h000, "R1 wrong key reads 0");
    do_write(12'h000, KEY, "R1 right key");
    do_read(12'h000, "R1 key reads 1");
    chk(unlocked == 1'b1, "R1 unlocked flag", 32'(unlocked), 1);
    // R3 / R4
    do_write(12'h070, 32'h8000_0001, "R3 strap or");
    do_read(12'h070, "R3 strap or result");
    do_write(12'h07C, 32'h00F0_0001, "R4 strap clear");
    do_read(12'h070, "R4 strap clear result");
    do_read(12'h07C, "R4 revision unchanged");
    // R5
    do_write(12'h050, 32'hDEAD_BEEF, "R5 scratch store");
    do_read(12'h050, "R5 scratch held");
    do_write(12'h150, 32'h0, "R5 id store");
    do_read(12'h150, "R5 id held");
    // R9 / R6
    do_write(12'h00A, 32'h5555_5555, "R9 misaligned store");
    do_read(12'h008, "R9 neighbour unchanged");
    do_read(12'h00A, "R9 misaligned read");
    do_write(12'h1AC, 32'h7777_7777, "R6 out of range store");
    do_read(12'h1AC, "R6 out of range read");
    // R7
    do_read(12'h078, "R7 random word a");
    do_read(12'h078, "R7 random word b");
    // R12 inside span while unlocked
    do_write(12'h004, 32'hA5A5_5A5A, "R12 unlocked store");
    do_read(12'h004, "R12 unlocked readback");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = 12'(($urandom % 112) * 4);
      if ($urandom % 16 == 0) a = a | 12'(1 + $urandom % 3);
      if ($urandom % 6 == 0) a = 12'h000;
      d = $urandom;
      if ($urandom % 3 == 0) d = KEY;
      if ($urandom % 2 == 0) do_write(a, d, tag_of(a));
      else                   do_read(a, tag_of(a));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule